// File: doc/BRIEF.md
# Type-0 PCI Configuration Header Register File

This block holds the 64-byte standard header of one PCI function's configuration space. A host-side agent reads or writes the header at a byte offset with an access width of one, two or four bytes. Reads return the addressed bytes one cycle later. Writes are filtered register by register: some fields take the new value, some silently drop it, and some reject the access with an error pulse.

Every reset value comes from a parameter, and so does the size of each of the six base address registers. The base address registers and the expansion ROM register follow the standard sizing handshake. An all-ones write makes the register report the size it decodes. The low type bits of a base address register stay read-only: two bits for an I/O register (bit 0 set) and four bits for a memory register. Software discovers the window sizes this way and then programs the real base addresses.

Top module: `pci_cfg_header`

## Requirements
- R1: A legal read (size code 1, 2 or 4, every byte inside offsets 0x00 to 0x3F) returns its bytes on `rd_data` in the cycle after the access. The byte at the addressed offset goes in bits [7:0], and higher offsets fill the higher bytes (little-endian). Bytes beyond the access width read as zero. `rd_data` keeps its value in every cycle without a legal read.
- R2: An access is illegal if its size code is not 1, 2 or 4, if its offset is 0x40 or above, or if its last byte would fall past 0x3F. An illegal access raises `acc_err` for exactly the following cycle. It changes no header byte and leaves `rd_data` unchanged. `acc_err` is low in every cycle that does not follow an illegal access or an error-raising write.
- R3: A one-byte write changes only the cache line size (0x0C), the latency timer (0x0D) and the interrupt line (0x3C). A one-byte write to the revision (0x08), the class code (0x0B), the interrupt pin (0x3D), the minimum grant (0x3E) or the maximum latency (0x3F) is dropped without error. A one-byte write to any other offset raises `acc_err` and changes nothing.
- R4: A two-byte write is accepted only at the command (0x04), status (0x06) and cache-line-size (0x0C) offsets, and it stores both bytes there. A two-byte write at any other offset raises `acc_err` and changes nothing.
- R5: A four-byte write of 0xFFFFFFFF to a base address register (offsets 0x10, 0x14, 0x18, 0x1C, 0x20, 0x24; index = (offset − 0x10) >> 2) stores ~(size − 1), where size is that register's size parameter. The low 2 bits keep their old value if bit 0 was 1 (I/O), and the low 4 bits keep their old value otherwise (memory).
- R6: A four-byte write of any other value to a base address register stores the written value, except that the read-only low bits (2 for I/O, 4 for memory) keep their old value.
- R7: A four-byte write of 0xFFFFFFFE to the expansion ROM register (0x30) makes it read 0xFFFFFFFF. Any other value is stored as written.
- R8: A four-byte write to the command offset (0x04) updates the 16-bit command field only, and the status field at 0x06 is kept. A four-byte write to any offset other than the base address registers, the ROM register and 0x04 is dropped without error.
- R9: Reset loads the whole header from the parameters and clears `rd_data` and `acc_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | OFF_W | Byte offset of the access |
| acc_size | input | 3 | Access width in bytes; 1, 2 and 4 are legal |
| acc_wdata | input | 32 | Write data, least significant byte at the addressed offset |
| rd_data | output | 32 | Read result, valid the cycle after a legal read |
| acc_err | output | 1 | One-cycle pulse after an illegal access |

## Verification
The reads are tried at all three widths against fields of known reset value. This separates byte ordering, upper-byte zeroing and width decoding.

Writes are tried at each width against three kinds of offset: writable, silently read-only and error-raising. This shows whether the permission decoding depends on width as well as on offset.

Base address registers are tried with an all-ones pattern and with ordinary values. They include an I/O register, a memory register and a register whose size parameter is zero. These cases separate the sizing mask from plain storage and the 2-bit type rule from the 4-bit one.

The ROM register gets both its trigger value and an ordinary value. Illegal widths and out-of-range offsets follow a read, which shows that read data is held and that the error pulse lasts one cycle.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;

    localparam int HDR_BYTES  = 64;
    localparam int NUM_BARS   = 6;
    localparam int WORD_BYTES = 4;

    // Header field offsets whose decoding the write rules depend on
    localparam int OFS_CMD     = 'h04;
    localparam int OFS_STAT    = 'h06;
    localparam int OFS_REV     = 'h08;
    localparam int OFS_CLASS   = 'h0B;
    localparam int OFS_CLS     = 'h0C;
    localparam int OFS_LAT     = 'h0D;
    localparam int OFS_BAR0    = 'h10;
    localparam int OFS_BARLAST = OFS_BAR0 + WORD_BYTES * (NUM_BARS - 1);
    localparam int OFS_ROM     = 'h30;
    localparam int OFS_INTLINE = 'h3C;
    localparam int OFS_INTPIN  = 'h3D;
    localparam int OFS_MINGNT  = 'h3E;
    localparam int OFS_MAXLAT  = 'h3F;

    typedef enum logic [2:0] {
        WR_NONE,
        WR_RAW,
        WR_BAR,
        WR_ROM,
        WR_CMD
    } wr_op_e;

    typedef struct packed {
        logic [HDR_BYTES-1:0][7:0] hdr;
        logic [31:0]               rdata;
        logic                      err;
    } cfg_state_t;

endpackage

// File: rtl/pci_cfg_decode.sv
module pci_cfg_decode
    import pci_cfg_pkg::*;
#(
    parameter int OFF_W = 8
) (
    input  logic             valid,
    input  logic             write,
    input  logic [OFF_W-1:0] offset,
    input  logic [2:0]       size,
    output logic             illegal,
    output logic             rd_ok,
    output wr_op_e           op,
    output logic [2:0]       bar_idx
);

    localparam int EW = OFF_W + 1;

    logic             size_ok;
    logic             in_range;
    logic [EW-1:0]    end_off;
    logic [OFF_W-1:0] bar_rel;
    logic             is_bar;

    always_comb begin
        size_ok  = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
        end_off  = {1'b0, offset} + EW'(size);
        in_range = (offset < OFF_W'(HDR_BYTES)) && (end_off <= EW'(HDR_BYTES));
        bar_rel  = offset - OFF_W'(OFS_BAR0);
        is_bar   = (offset >= OFF_W'(OFS_BAR0)) && (offset <= OFF_W'(OFS_BARLAST))
                   && (offset[1:0] == 2'b00);

        illegal = 1'b0;
        rd_ok   = 1'b0;
        op      = WR_NONE;
        bar_idx = bar_rel[4:2];

        if (valid) begin
            if (!size_ok || !in_range) begin
                illegal = 1'b1;
            end else if (!write) begin
                rd_ok = 1'b1;
            end else begin
                unique case (size)
                    3'd1: begin
                        if (offset == OFF_W'(OFS_CLS) || offset == OFF_W'(OFS_LAT)
                            || offset == OFF_W'(OFS_INTLINE)) begin
                            op = WR_RAW;
                        end else if (offset == OFF_W'(OFS_REV) || offset == OFF_W'(OFS_CLASS)
                            || offset == OFF_W'(OFS_INTPIN) || offset == OFF_W'(OFS_MINGNT)
                            || offset == OFF_W'(OFS_MAXLAT)) begin
                            op = WR_NONE;
                        end else begin
                            illegal = 1'b1;
                        end
                    end
                    3'd2: begin
                        if (offset == OFF_W'(OFS_CMD) || offset == OFF_W'(OFS_STAT)
                            || offset == OFF_W'(OFS_CLS)) begin
                            op = WR_RAW;
                        end else begin
                            illegal = 1'b1;
                        end
                    end
                    default: begin
                        if (is_bar) begin
                            op = WR_BAR;
                        end else if (offset == OFF_W'(OFS_ROM)) begin
                            op = WR_ROM;
                        end else if (offset == OFF_W'(OFS_CMD)) begin
                            op = WR_CMD;
                        end else begin
                            op = WR_NONE;
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/pci_cfg_bar_calc.sv
module pci_cfg_bar_calc (
    input  logic [31:0] old_val,
    input  logic [31:0] wdata,
    input  logic [31:0] win_size,
    output logic [31:0] new_val
);

    logic [31:0] ro_mask;
    logic [31:0] base;

    always_comb begin
        // bit 0 marks an I/O window: two type bits, otherwise four
        ro_mask = old_val[0] ? 32'h0000_0003 : 32'h0000_000F;
        if (wdata == 32'hFFFF_FFFF) begin
            base = ~(win_size - 32'd1);
        end else begin
            base = wdata;
        end
        new_val = (base & ~ro_mask) | (old_val & ro_mask);
    end

endmodule

// File: rtl/pci_cfg_rd_mux.sv
module pci_cfg_rd_mux
    import pci_cfg_pkg::*;
#(
    parameter int OFF_W = 8
) (
    input  logic [HDR_BYTES-1:0][7:0] hdr,
    input  logic [OFF_W-1:0]          offset,
    input  logic [2:0]                size,
    output logic [31:0]               word
);

    logic [5:0] base;

    always_comb begin
        base = offset[5:0];
        word = '0;
        for (int i = 0; i < WORD_BYTES; i++) begin
            if (i < int'(size)) begin
                word[8*i +: 8] = hdr[base + 6'(i)];
            end
        end
    end

endmodule

// File: rtl/pci_cfg_header.sv
module pci_cfg_header
    import pci_cfg_pkg::*;
#(
    parameter int                       OFF_W      = 8,
    parameter logic [31:0]              P_ID       = 32'h1234_ABCD,
    parameter logic [31:0]              P_CMD_STAT = 32'h0200_0000,
    parameter logic [31:0]              P_CLASS_RV = 32'h0200_0001,
    parameter logic [31:0]              P_MISC     = 32'h0000_0000,
    parameter logic [32*NUM_BARS-1:0]   P_BAR_INIT = {32'h0, 32'h0, 32'h0, 32'h0,
                                                      32'h0000_0008, 32'h0000_0001},
    parameter logic [32*NUM_BARS-1:0]   P_BAR_SIZE = {32'h0000_0020, 32'h0010_0000,
                                                      32'h0000_0040, 32'h0000_0000,
                                                      32'h0000_1000, 32'h0000_0100},
    parameter logic [31:0]              P_CIS      = 32'h0000_0000,
    parameter logic [31:0]              P_SUBSYS   = 32'h5678_1234,
    parameter logic [31:0]              P_ROM      = 32'h0000_0000,
    parameter logic [31:0]              P_INTR     = 32'h0A05_010B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [OFF_W-1:0] acc_offset,
    input  logic [2:0]       acc_size,
    input  logic [31:0]      acc_wdata,
    output logic [31:0]      rd_data,
    output logic             acc_err
);

    localparam int HDR_WORDS = HDR_BYTES / WORD_BYTES;
    localparam int BAR_WORD0 = OFS_BAR0 / WORD_BYTES;
    localparam int IDX_SLOTS = 8;

    function automatic logic [HDR_BYTES-1:0][7:0] build_image();
        logic [HDR_WORDS-1:0][31:0] dw;
        dw     = '0;
        dw[0]  = P_ID;
        dw[1]  = P_CMD_STAT;
        dw[2]  = P_CLASS_RV;
        dw[3]  = P_MISC;
        for (int b = 0; b < NUM_BARS; b++) begin
            dw[BAR_WORD0 + b] = P_BAR_INIT[32*b +: 32];
        end
        dw[10] = P_CIS;
        dw[11] = P_SUBSYS;
        dw[12] = P_ROM;
        dw[15] = P_INTR;
        return dw;
    endfunction

    localparam logic [HDR_BYTES-1:0][7:0] RST_IMG = build_image();

    cfg_state_t st_d, st_q;
    logic [HDR_BYTES-1:0][7:0] hdr_q;

    logic        illegal;
    logic        rd_ok;
    wr_op_e      op;
    logic [2:0]  bar_idx;
    logic [31:0] cur_word;
    logic [31:0] bar_new;
    logic [31:0] sel_size;
    logic [31:0] bar_size [IDX_SLOTS];
    logic [31:0] wval;
    int          nbytes;
    logic [5:0]  off6;

    for (genvar g = 0; g < IDX_SLOTS; g++) begin : g_size
        if (g < NUM_BARS) begin : g_real
            assign bar_size[g] = P_BAR_SIZE[32*g +: 32];
        end else begin : g_pad
            assign bar_size[g] = '0;
        end
    end

    pci_cfg_decode #(.OFF_W(OFF_W)) u_dec (
        .valid   (acc_valid),
        .write   (acc_write),
        .offset  (acc_offset),
        .size    (acc_size),
        .illegal (illegal),
        .rd_ok   (rd_ok),
        .op      (op),
        .bar_idx (bar_idx)
    );

    pci_cfg_rd_mux #(.OFF_W(OFF_W)) u_rd (
        .hdr    (st_q.hdr),
        .offset (acc_offset),
        .size   (acc_size),
        .word   (cur_word)
    );

    assign sel_size = bar_size[bar_idx];

    pci_cfg_bar_calc u_bar (
        .old_val  (cur_word),
        .wdata    (acc_wdata),
        .win_size (sel_size),
        .new_val  (bar_new)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = illegal;
        off6     = acc_offset[5:0];

        if (rd_ok) begin
            st_d.rdata = cur_word;
        end

        unique case (op)
            WR_RAW: begin
                wval   = acc_wdata;
                nbytes = int'(acc_size);
            end
            WR_BAR: begin
                wval   = bar_new;
                nbytes = WORD_BYTES;
            end
            WR_ROM: begin
                wval   = (acc_wdata == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : acc_wdata;
                nbytes = WORD_BYTES;
            end
            WR_CMD: begin
                wval   = acc_wdata;
                nbytes = 2;
            end
            default: begin
                wval   = '0;
                nbytes = 0;
            end
        endcase

        for (int j = 0; j < WORD_BYTES; j++) begin
            if (j < nbytes) begin
                st_d.hdr[off6 + 6'(j)] = wval[8*j +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{hdr: RST_IMG, rdata: 32'h0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign hdr_q   = st_q.hdr;
    assign rd_data = st_q.rdata;
    assign acc_err = st_q.err;

endmodule

// File: rtl/pci_cfg_header_chk.sv
module pci_cfg_header_chk
    import pci_cfg_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic                      acc_valid,
    input logic                      acc_write,
    input logic [31:0]               rd_data,
    input logic                      err,
    input logic [HDR_BYTES-1:0][7:0] hdr
);

    logic [NUM_BARS-1:0] bar_type;
    logic [31:0]         rom_word;
    logic [31:0]         id_word;

    always_comb begin
        for (int b = 0; b < NUM_BARS; b++) begin
            bar_type[b] = hdr[OFS_BAR0 + WORD_BYTES*b][0];
        end
        rom_word = {hdr[OFS_ROM+3], hdr[OFS_ROM+2], hdr[OFS_ROM+1], hdr[OFS_ROM]};
        id_word  = {hdr[3], hdr[2], hdr[1], hdr[0]};
    end

    AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !err); // R2

    AST_ERR_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (hdr == $past(hdr))); // R2

    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid || acc_write) |=> $stable(rd_data)); // R1

    AST_BAR_TYPE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(bar_type)); // R6

    AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(id_word)); // R8

    AST_ROM_NO_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        rom_word != 32'hFFFF_FFFE); // R7

endmodule

bind pci_cfg_header pci_cfg_header_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .rd_data   (rd_data),
    .err       (acc_err),
    .hdr       (hdr_q)
);

// File: tb/pci_cfg_header_tb.sv
module pci_cfg_header_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid;
    logic        acc_write;
    logic [7:0]  acc_offset;
    logic [2:0]  acc_size;
    logic [31:0] acc_wdata;
    logic [31:0] rd_data;
    logic        acc_err;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pci_cfg_header u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_offset (acc_offset),
        .acc_size   (acc_size),
        .acc_wdata  (acc_wdata),
        .rd_data    (rd_data),
        .acc_err    (acc_err)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  sz;
        logic [7:0]  off;
        logic [31:0] wd;
        logic        chk;
        logic [31:0] exp_rd;
        logic        exp_err;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 43;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd4, 8'h00, 32'h0,        1'b1, 32'h1234_ABCD, 1'b0, 8'd1}, // R1
        '{1'b0, 3'd2, 8'h02, 32'h0,        1'b1, 32'h0000_1234, 1'b0, 8'd1}, // R1
        '{1'b0, 3'd1, 8'h08, 32'h0,        1'b1, 32'h0000_0001, 1'b0, 8'd1}, // R1
        '{1'b0, 3'd4, 8'h3C, 32'h0,        1'b1, 32'h0A05_010B, 1'b0, 8'd1}, // R1
        '{1'b0, 3'd1, 8'h3F, 32'h0,        1'b1, 32'h0000_000A, 1'b0, 8'd1}, // R1
        '{1'b1, 3'd1, 8'h3C, 32'h77,       1'b0, 32'h0,         1'b0, 8'd3}, // R3
        '{1'b0, 3'd1, 8'h3C, 32'h0,        1'b1, 32'h0000_0077, 1'b0, 8'd3}, // R3
        '{1'b1, 3'd1, 8'h3D, 32'h99,       1'b0, 32'h0,         1'b0, 8'd3}, // R3
        '{1'b0, 3'd4, 8'h3C, 32'h0,        1'b1, 32'h0A05_0177, 1'b0, 8'd3}, // R3
        '{1'b1, 3'd1, 8'h0B, 32'h33,       1'b0, 32'h0,         1'b0, 8'd3}, // R3
        '{1'b0, 3'd4, 8'h08, 32'h0,        1'b1, 32'h0200_0001, 1'b0, 8'd3}, // R3
        '{1'b1, 3'd1, 8'h0D, 32'h66,       1'b0, 32'h0,         1'b0, 8'd3}, // R3
        '{1'b1, 3'd1, 8'h00, 32'h55,       1'b0, 32'h0,         1'b1, 8'd3}, // R3
        '{1'b0, 3'd2, 8'h00, 32'h0,        1'b1, 32'h0000_ABCD, 1'b0, 8'd3}, // R3
        '{1'b1, 3'd2, 8'h04, 32'h0147,     1'b0, 32'h0,         1'b0, 8'd4}, // R4
        '{1'b0, 3'd4, 8'h04, 32'h0,        1'b1, 32'h0200_0147, 1'b0, 8'd4}, // R4
        '{1'b1, 3'd2, 8'h0C, 32'h4020,     1'b0, 32'h0,         1'b0, 8'd4}, // R4
        '{1'b0, 3'd2, 8'h0C, 32'h0,        1'b1, 32'h0000_4020, 1'b0, 8'd4}, // R4
        '{1'b1, 3'd2, 8'h08, 32'h1111,     1'b0, 32'h0,         1'b1, 8'd4}, // R4
        '{1'b0, 3'd4, 8'h08, 32'h0,        1'b1, 32'h0200_0001, 1'b0, 8'd4}, // R4
        '{1'b1, 3'd4, 8'h10, 32'hFFFF_FFFF, 1'b0, 32'h0,        1'b0, 8'd5}, // R5
        '{1'b0, 3'd4, 8'h10, 32'h0,        1'b1, 32'hFFFF_FF01, 1'b0, 8'd5}, // R5
        '{1'b1, 3'd4, 8'h14, 32'hFFFF_FFFF, 1'b0, 32'h0,        1'b0, 8'd5}, // R5
        '{1'b0, 3'd4, 8'h14, 32'h0,        1'b1, 32'hFFFF_F008, 1'b0, 8'd5}, // R5
        '{1'b1, 3'd4, 8'h18, 32'hFFFF_FFFF, 1'b0, 32'h0,        1'b0, 8'd5}, // R5
        '{1'b0, 3'd4, 8'h18, 32'h0,        1'b1, 32'h0000_0000, 1'b0, 8'd5}, // R5
        '{1'b1, 3'd4, 8'h1C, 32'hFFFF_FFFF, 1'b0, 32'h0,        1'b0, 8'd5}, // R5
        '{1'b0, 3'd4, 8'h1C, 32'h0,        1'b1, 32'hFFFF_FFC0, 1'b0, 8'd5}, // R5
        '{1'b1, 3'd4, 8'h10, 32'h0000_C0F2, 1'b0, 32'h0,        1'b0, 8'd6}, // R6
        '{1'b0, 3'd4, 8'h10, 32'h0,        1'b1, 32'h0000_C0F1, 1'b0, 8'd6}, // R6
        '{1'b1, 3'd4, 8'h14, 32'h8000_0007, 1'b0, 32'h0,        1'b0, 8'd6}, // R6
        '{1'b0, 3'd4, 8'h14, 32'h0,        1'b1, 32'h8000_0008, 1'b0, 8'd6}, // R6
        '{1'b1, 3'd4, 8'h30, 32'hFFFF_FFFE, 1'b0, 32'h0,        1'b0, 8'd7}, // R7
        '{1'b0, 3'd4, 8'h30, 32'h0,        1'b1, 32'hFFFF_FFFF, 1'b0, 8'd7}, // R7
        '{1'b1, 3'd4, 8'h30, 32'h000C_0001, 1'b0, 32'h0,        1'b0, 8'd7}, // R7
        '{1'b0, 3'd4, 8'h30, 32'h0,        1'b1, 32'h000C_0001, 1'b0, 8'd7}, // R7
        '{1'b1, 3'd4, 8'h00, 32'hDEAD_BEEF, 1'b0, 32'h0,        1'b0, 8'd8}, // R8
        '{1'b0, 3'd4, 8'h00, 32'h0,        1'b1, 32'h1234_ABCD, 1'b0, 8'd8}, // R8
        '{1'b1, 3'd4, 8'h04, 32'hFFFF_0005, 1'b0, 32'h0,        1'b0, 8'd8}, // R8
        '{1'b0, 3'd4, 8'h04, 32'h0,        1'b1, 32'h0200_0005, 1'b0, 8'd8}, // R8
        '{1'b0, 3'd3, 8'h00, 32'h0,        1'b1, 32'h0200_0005, 1'b1, 8'd2}, // R2
        '{1'b0, 3'd4, 8'h40, 32'h0,        1'b1, 32'h0200_0005, 1'b1, 8'd2}, // R2
        '{1'b0, 3'd4, 8'h3E, 32'h0,        1'b1, 32'h0200_0005, 1'b1, 8'd2}  // R2
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive at a falling edge; results are visible at the next falling edge
    task automatic access(input logic wr, input logic [2:0] sz,
                          input logic [7:0] off, input logic [31:0] wd);
        acc_valid  = 1'b1;
        acc_write  = wr;
        acc_size   = sz;
        acc_offset = off;
        acc_wdata  = wd;
        @(negedge clk);
        acc_valid  = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        acc_valid  = 1'b0;
        acc_write  = 1'b0;
        acc_offset = '0;
        acc_size   = 3'd4;
        acc_wdata  = '0;
        repeat (3) @(negedge clk);
        check(9, "reset rd_data", rd_data, 32'h0);          // R9
        check(9, "reset acc_err", {31'b0, acc_err}, 32'h0); // R9
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            access(VECS[k].wr, VECS[k].sz, VECS[k].off, VECS[k].wd);
            check(int'(VECS[k].req), "acc_err", {31'b0, acc_err}, {31'b0, VECS[k].exp_err});
            if (VECS[k].chk) begin
                check(int'(VECS[k].req), "rd_data", rd_data, VECS[k].exp_rd);
            end
        end

        // R2: error lasts one cycle once the bus goes idle
        access(1'b0, 3'd0, 8'h00, 32'h0);
        check(2, "err pulse", {31'b0, acc_err}, 32'h1);
        @(negedge clk);
        check(2, "err cleared", {31'b0, acc_err}, 32'h0);

        // R2: rejected halfword write beyond the header leaves 0x3C..0x3F alone
        access(1'b1, 3'd2, 8'h3F, 32'hBEEF);
        check(2, "end overrun err", {31'b0, acc_err}, 32'h1);
        access(1'b0, 3'd4, 8'h3C, 32'h0);
        check(2, "overrun no store", rd_data, 32'h0A05_0177);

        // R9: reset restores parameter values after sizing writes
        access(1'b1, 3'd4, 8'h10, 32'hFFFF_FFFF);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        access(1'b0, 3'd4, 8'h10, 32'h0);
        check(9, "BAR0 after reset", rd_data, 32'h0000_0001);
        access(1'b0, 3'd4, 8'h30, 32'h0);
        check(9, "ROM after reset", rd_data, 32'h0000_0000);
        access(1'b0, 3'd4, 8'h04, 32'h0);
        check(9, "cmd/status after reset", rd_data, 32'h0200_0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule